// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Hold-Off

This block is a fixed-depth hardware stack that keeps program-counter values for a small processor core. A subroutine call or an accepted interrupt pushes the current program counter, and a return instruction (from a subroutine or an interrupt) pops the most recent value back into the program counter. The stack has no software path: nothing in the data or program space can read it, write it, or see its pointer.

The block also decides whether an interrupt can be accepted. While every level is occupied, a pending interrupt is not acknowledged. The interrupt controller keeps the request pending, and the block acknowledges it as soon as a return has freed a level. A call on a full stack works differently. It is never held back: it overwrites the oldest saved address, so the stack always keeps the most recent return addresses.

The storage is a circular buffer that holds a slot pointer and an occupancy count. A full-stack call advances the pointer around the ring and leaves the count unchanged.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty: `full_o` is 0 and `ack_allow_o` is 1.
- R2: The stack holds `DEPTH` (default 6) entries. `full_o` is 1 exactly when `DEPTH` entries are held, and `ack_allow_o` is always the inverse of `full_o`.
- R3: A push stores `push_pc_i` as the newest entry at the clock edge. A push happens when `call_i` is 1 and `ret_i` is 0, or when an interrupt is acknowledged. Pushes nest.
- R4: While `ret_i` is 1 on a non-empty stack, `pop_pc_o` presents the newest entry in that same cycle. The entry is removed at the clock edge.
- R5: `irq_ack_o` is 1 in a cycle exactly when `irq_req_i` is 1, the stack is not full, and neither `call_i` nor `ret_i` is 1. The acknowledged interrupt pushes `push_pc_i` at the edge of that same cycle.
- R6: While the stack is full, `irq_ack_o` stays 0. A request held high through a return is acknowledged in the first cycle after the edge at which `ret_i` popped.
- R7: A push on a full stack discards the oldest entry and keeps the stack full. Successive pops then return the `DEPTH` most recent pushed values, newest first.
- R8: A return on an empty stack changes no state. The count stays 0, and exactly `DEPTH` later pushes are needed before `full_o` rises.
- R9: If `call_i` and `ret_i` are both 1 in the same cycle, the pop takes effect and the call is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_i | input | 1 | Subroutine call in this cycle |
| ret_i | input | 1 | Return (subroutine or interrupt) in this cycle |
| irq_req_i | input | 1 | Pending unmasked interrupt from the controller |
| push_pc_i | input | PC_W | Program counter value to save |
| pop_pc_o | output | PC_W | Newest saved value, restored to the program counter on a return |
| irq_ack_o | output | 1 | Interrupt acknowledged this cycle |
| full_o | output | 1 | All levels occupied |
| ack_allow_o | output | 1 | Interrupt acknowledge permitted (not full) |

## Verification
On every cycle, the assertions check these rules:
- The count stays within bounds.
- A push grows the count, or holds it at the top when the stack is full.
- A pop shrinks the count, and an empty pop leaves it at zero.
- No acknowledge is issued while the stack is full, and a return from a full stack clears the full flag.
- The value just pushed is the one presented for the next pop.

Only the bench scenarios can show the history-dependent behaviour:
- the order of values across deep nesting;
- which six addresses survive a call on a full stack;
- that an interrupt held off while full is taken right after the return;
- that an empty pop leaves no trace in later occupancy.

// File: rtl/rastk_pkg.sv
package rastk_pkg;

   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;

   function automatic int unsigned ring_next(input int unsigned idx, input int unsigned depth);
      return (idx == depth - 1) ? 0 : idx + 1;
   endfunction

   function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned depth);
      return (idx == 0) ? depth - 1 : idx - 1;
   endfunction

endpackage

// File: rtl/rastk_gate.sv
module rastk_gate
   import rastk_pkg::*;
(
   input  logic    call_i,
   input  logic    ret_i,
   input  logic    irq_req_i,
   input  logic    full_i,
   output stk_op_e op_o,
   output logic    irq_ack_o,
   output logic    ack_allow_o
);

   logic ack_w;

   // an interrupt is taken only on a cycle free of call/return and with room left
   assign ack_w       = irq_req_i & ~full_i & ~call_i & ~ret_i;
   assign irq_ack_o   = ack_w;
   assign ack_allow_o = ~full_i;

   always_comb begin
      if (ret_i)               op_o = STK_POP;   // R9: return wins over call
      else if (call_i | ack_w) op_o = STK_PUSH;
      else                     op_o = STK_IDLE;
   end

endmodule

// File: rtl/rastk_ptr.sv
module rastk_ptr
   import rastk_pkg::*;
#(
   parameter int unsigned DEPTH = 6,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  stk_op_e          op_i,
   output logic [PTR_W-1:0] wr_idx_o,
   output logic [PTR_W-1:0] rd_idx_o,
   output logic             full_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   logic [PTR_W-1:0] ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] ptr_inc, ptr_dec;

   assign ptr_inc  = PTR_W'(ring_next(int'(ptr_q), DEPTH));
   assign ptr_dec  = PTR_W'(ring_prev(int'(ptr_q), DEPTH));
   assign wr_idx_o = ptr_q;
   assign rd_idx_o = ptr_dec;
   assign full_o   = (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (op_i)
            STK_PUSH: begin
               ptr_q <= ptr_inc;                         // wrap drops oldest when full
               if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end
            STK_POP: begin
               if (cnt_q != '0) begin
                  ptr_q <= ptr_dec;
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   p_push_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_PUSH && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

   p_pop_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_POP && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   p_full_stays_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_PUSH && full_o) |=> full_o);

   p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == STK_POP && cnt_q == '0) |=> (cnt_q == '0 && $stable(ptr_q)));

endmodule

// File: rtl/rastk_store.sv
module rastk_store #(
   parameter int unsigned DEPTH = 6,
   parameter int unsigned PC_W  = 13,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [PTR_W-1:0] widx_i,
   input  logic [PC_W-1:0]  wdata_i,
   input  logic [PTR_W-1:0] ridx_i,
   output logic [PC_W-1:0]  rdata_o
);

   logic [PC_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  slot_q[g] <= '0;
         else if (we_i && widx_i == PTR_W'(g))        slot_q[g] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ridx_i == PTR_W'(i)) rdata_o = slot_q[i];
      end
   end

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import rastk_pkg::*;
#(
   parameter int unsigned DEPTH = 6,
   parameter int unsigned PC_W  = 13
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic            ret_i,
   input  logic            irq_req_i,
   input  logic [PC_W-1:0] push_pc_i,
   output logic [PC_W-1:0] pop_pc_o,
   output logic            irq_ack_o,
   output logic            full_o,
   output logic            ack_allow_o
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("ret_addr_stack: DEPTH must be at least 2");
   end
   if (PC_W < 1 || PC_W > 32) begin : g_bad_pcw
      $error("ret_addr_stack: PC_W must be 1..32");
   end

   stk_op_e          op_w;
   logic [PTR_W-1:0] widx_w, ridx_w;
   logic             full_w;

   rastk_gate u_gate (
      .call_i      (call_i),
      .ret_i       (ret_i),
      .irq_req_i   (irq_req_i),
      .full_i      (full_w),
      .op_o        (op_w),
      .irq_ack_o   (irq_ack_o),
      .ack_allow_o (ack_allow_o)
   );

   rastk_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op_w),
      .wr_idx_o (widx_w),
      .rd_idx_o (ridx_w),
      .full_o   (full_w)
   );

   rastk_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (op_w == STK_PUSH),
      .widx_i  (widx_w),
      .wdata_i (push_pc_i),
      .ridx_i  (ridx_w),
      .rdata_o (pop_pc_o)
   );

   assign full_o = full_w;

   p_no_ack_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !irq_ack_o);

   p_ret_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && ret_i) |=> !full_o);

   p_push_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i) |=> (pop_pc_o == $past(push_pc_i)));

   p_ack_pushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack_o |=> (pop_pc_o == $past(push_pc_i)));

endmodule

// File: tb/ret_addr_stack_tb_top.sv
`timescale 1ns/1ps
module ret_addr_stack_tb_top;

   localparam int DEPTH = 6;
   localparam int PC_W  = 13;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            call_i, ret_i, irq_req_i;
   logic [PC_W-1:0] push_pc_i;
   logic [PC_W-1:0] pop_pc_o;
   logic            irq_ack_o, full_o, ack_allow_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   int model_q [DEPTH];
   int model_n;

   always #2.5 clk = ~clk;

   ret_addr_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .irq_req_i(irq_req_i), .push_pc_i(push_pc_i), .pop_pc_o(pop_pc_o),
      .irq_ack_o(irq_ack_o), .full_o(full_o), .ack_allow_o(ack_allow_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_ack(input bit c, input bit r, input bit q);
      return q && (model_n < DEPTH) && !c && !r;
   endfunction

   task automatic model_push(input int v);
      if (model_n == DEPTH) begin
         for (int i = 0; i < DEPTH - 1; i++) model_q[i] = model_q[i+1];
         model_q[DEPTH-1] = v;
      end else begin
         model_q[model_n] = v;
         model_n++;
      end
   endtask

   // drive after negedge, check combinational outputs, then let the edge act
   task automatic step(input bit c, input bit r, input bit q, input int pc);
      bit ea;
      @(negedge clk);
      call_i = c; ret_i = r; irq_req_i = q; push_pc_i = PC_W'(pc);
      #1;
      ea = exp_ack(c, r, q);
      check(irq_ack_o == ea, (model_n == DEPTH) ? "R6 ack" : "R5 ack", irq_ack_o, ea);
      check(full_o == (model_n == DEPTH), "R2 full", full_o, model_n == DEPTH);
      check(ack_allow_o == (model_n != DEPTH), "R2 ack_allow", ack_allow_o, model_n != DEPTH);
      if (r && model_n > 0)
         check(pop_pc_o == PC_W'(model_q[model_n-1]), "R4 pop value", pop_pc_o, model_q[model_n-1]);
      @(posedge clk);
      if (r) begin
         if (model_n > 0) model_n--;
      end else if (c || ea) begin
         model_push(pc);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; call_i = 0; ret_i = 0; irq_req_i = 0; push_pc_i = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_n = 0;
   endtask

   task automatic show_pop(input string tag, input int exp);
      @(negedge clk);
      call_i = 0; ret_i = 1; irq_req_i = 0; #1;
      check(pop_pc_o == PC_W'(exp), tag, pop_pc_o, exp);
      @(posedge clk);
      if (model_n > 0) model_n--;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0123));
      rst_n = 1'b0;
      do_reset();

      // R1: reset state
      #1;
      check(full_o == 1'b0, "R1 full after reset", full_o, 0);
      check(ack_allow_o == 1'b1, "R1 ack_allow after reset", ack_allow_o, 1);

      // R3/R2: nest to depth six, full exactly at six
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 100 + i);
      #1; check(full_o == 1'b1, "R2 full at six", full_o, 1);
      for (int i = DEPTH - 1; i >= 0; i--) show_pop("R3 nested order", 100 + i);
      #1; check(full_o == 1'b0, "R2 empty again", full_o, 0);

      // R7: seventh call drops oldest
      do_reset();
      for (int i = 1; i <= DEPTH + 1; i++) step(1, 0, 0, i);
      #1; check(full_o == 1'b1, "R7 still full", full_o, 1);
      for (int i = DEPTH + 1; i >= 2; i--) show_pop("R7 recent kept", i);
      #1; check(full_o == 1'b0 && ack_allow_o == 1'b1, "R7 drained", full_o, 0);

      // R6: interrupt held off while full, taken after return
      do_reset();
      for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 200 + i);
      repeat (3) step(0, 0, 1, 300);
      step(0, 1, 1, 300);
      @(negedge clk); call_i = 0; ret_i = 0; irq_req_i = 1; push_pc_i = PC_W'(777); #1;
      check(irq_ack_o == 1'b1, "R6 ack after return", irq_ack_o, 1);
      @(posedge clk); model_push(777);
      #1; check(full_o == 1'b1, "R5 ack pushed", full_o, 1);
      show_pop("R5 ack saved pc", 777);

      // R8: empty pop leaves no trace
      do_reset();
      step(0, 1, 0, 0);
      step(0, 1, 0, 0);
      for (int i = 0; i < DEPTH - 1; i++) step(1, 0, 0, 50 + i);
      #1; check(full_o == 1'b0, "R8 not full after five", full_o, 0);
      step(1, 0, 0, 60);
      #1; check(full_o == 1'b1, "R8 full after six", full_o, 1);

      // R9: call and return together, return wins
      do_reset();
      step(1, 0, 0, 11);
      step(1, 0, 0, 22);
      step(1, 1, 0, 33);
      show_pop("R9 call ignored", 11);

      // constrained random mix
      do_reset();
      for (int k = 0; k < 4000; k++) begin
         bit c, r, q;
         int sel;
         sel = $urandom_range(0, 9);
         c = (sel < 4);
         r = (sel >= 3 && sel < 7);
         q = ($urandom_range(0, 2) == 0);
         step(c, r, q, int'($urandom_range(0, (1 << PC_W) - 1)));
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule